// File: doc/BRIEF.md
# Transmit Queue Start Controller

This block sits beside a transmit packet buffer. It decides when the packet at the head of the buffer may begin to drain toward the MAC. The write side reports each byte it pushes and flags the byte that ends a packet. The read side reports each byte it pops and flags the final byte of the packet it is draining. From these two streams the block keeps a count of the bytes held and a count of the complete packets held. From those counts it drives a single start-permission output.

Two policies are available, selected by a mode input. In whole-packet mode, permission is withheld until the head packet is completely stored. In early-start mode, permission is given as soon as the head packet's stored byte count passes a threshold. A 3-bit code selects that threshold from a non-linear table. A short packet whose end has already been written is released at once, whatever its length. After a packet has begun to drain, permission stays asserted until its last byte has left. The decision is then taken again for the next packet.

Top module: `txq_start_ctrl`

## Requirements
- R1: After reset, `start_ok` is 0 and `held_bytes` is 0.
- R2: With `cfg_sf_en`=1 and no packet draining, `start_ok` is 1 only when at least one packet whose end byte has been written is held. A partial packet of any length gives 0.
- R3: With `cfg_sf_en`=0 and no complete packet held, `start_ok` is 1 exactly when `held_bytes` is strictly greater than the selected threshold. The code values map as follows: 0 gives 64, 2 gives 96, 3 gives 128, 4 gives 192, 5 gives 256, 6 gives 384 and 7 gives 512.
- R4: Threshold code 1 is reserved and behaves as 64 bytes.
- R5: With `cfg_sf_en`=0, a complete packet shorter than the threshold gets `start_ok`=1 once its end byte is written.
- R6: While `cfg_sf_en`=1, the value of `cfg_thr_code` has no effect on `start_ok`.
- R7: Once a byte of a packet has been popped without the end flag, `start_ok` stays 1 until the pop carrying `rd_last`. This holds even if `held_bytes` drops below the threshold or the mode or code changes in the meantime.
- R8: After the last byte of a packet is popped, permission is decided again for the next packet from its own held bytes.
- R9: `held_bytes` counts +1 per push and −1 per pop. It saturates at 2^CNT_W−1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sf_en | input | 1 | 1 = whole-packet mode, 0 = threshold mode |
| cfg_thr_code | input | 3 | Threshold code for threshold mode |
| wr_push | input | 1 | One byte written into the buffer |
| wr_last | input | 1 | The pushed byte ends its packet |
| rd_pop | input | 1 | One byte read out of the buffer |
| rd_last | input | 1 | The popped byte ends its packet |
| held_bytes | output | CNT_W | Bytes currently held in the buffer |
| start_ok | output | 1 | Head packet may be (or keep being) transmitted |

## Verification
The hardest situation to reach is a packet already draining while its held byte count has fallen back under the threshold. That case must show permission held by the draining state rather than by the count. The bench reaches it by filling a packet just past the 64-byte threshold and popping enough bytes to go below it. It then flips the mode and code before checking. Saturation needs more bytes than the default counter can hold, so the bench uses a 10-bit counter and pushes 1100 bytes without an end flag.

// File: rtl/txq_start_pkg.sv
package txq_start_pkg;

  localparam int THR_W = 10;

  typedef logic [2:0] thr_code_t;

  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_SEND = 1'b1
  } start_state_t;

  // Reserved code 1 is folded onto the smallest threshold.
  function automatic logic [THR_W-1:0] thr_bytes_of(input thr_code_t code);
    logic [THR_W-1:0] b;
    case (code)
      3'd0:    b = THR_W'(64);
      3'd1:    b = THR_W'(64);
      3'd2:    b = THR_W'(96);
      3'd3:    b = THR_W'(128);
      3'd4:    b = THR_W'(192);
      3'd5:    b = THR_W'(256);
      3'd6:    b = THR_W'(384);
      default: b = THR_W'(512);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/txq_sat_counter.sv
module txq_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec) begin
      cnt_en = (cnt_q != MAX_V);
      cnt_d  = cnt_q + W'(1);
    end else if (dec && !inc) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/txq_thr_decode.sv
module txq_thr_decode
  import txq_start_pkg::*;
(
  input  thr_code_t        code,
  output logic [THR_W-1:0] bytes
);

  assign bytes = thr_bytes_of(code);

endmodule

// File: rtl/txq_start_fsm.sv
module txq_start_fsm
  import txq_start_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_en,
  input  logic [THR_W-1:0] thr_bytes,
  input  logic [CNT_W-1:0] held,
  input  logic             pkt_nz,
  input  logic             rd_pop,
  input  logic             rd_last,
  output logic             sending,
  output logic             start_ok
);

  start_state_t state_q;
  start_state_t state_d;
  logic         over_thr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT: if (rd_pop && !rd_last) state_d = ST_SEND;
      ST_SEND: if (rd_pop && rd_last)  state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
    end else if (state_d != state_q) begin
      state_q <= state_d;
    end
  end

  assign over_thr = (held > CNT_W'(thr_bytes));
  assign sending  = (state_q == ST_SEND);
  assign start_ok = sending || pkt_nz || (!sf_en && over_thr);

endmodule

// File: rtl/txq_start_ctrl.sv
module txq_start_ctrl
  import txq_start_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int PKT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sf_en,
  input  logic [2:0]       cfg_thr_code,
  input  logic             wr_push,
  input  logic             wr_last,
  input  logic             rd_pop,
  input  logic             rd_last,
  output logic [CNT_W-1:0] held_bytes,
  output logic             start_ok
);

  logic [THR_W-1:0] thr_bytes;
  logic [PKT_W-1:0] pkt_cnt;
  logic             pkt_nz;
  logic             sending;

  txq_sat_counter #(.W(CNT_W)) u_byte_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_push),
    .dec   (rd_pop),
    .count (held_bytes)
  );

  txq_sat_counter #(.W(PKT_W)) u_pkt_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_push && wr_last),
    .dec   (rd_pop && rd_last),
    .count (pkt_cnt)
  );

  assign pkt_nz = (pkt_cnt != '0);

  txq_thr_decode u_thr (
    .code  (cfg_thr_code),
    .bytes (thr_bytes)
  );

  txq_start_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sf_en     (cfg_sf_en),
    .thr_bytes (thr_bytes),
    .held      (held_bytes),
    .pkt_nz    (pkt_nz),
    .rd_pop    (rd_pop),
    .rd_last   (rd_last),
    .sending   (sending),
    .start_ok  (start_ok)
  );

endmodule

// File: rtl/txq_start_ctrl_chk.sv
module txq_start_ctrl_chk #(
  parameter int CNT_W = 15,
  parameter int THR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_sf_en,
  input logic             wr_push,
  input logic             rd_pop,
  input logic             rd_last,
  input logic [CNT_W-1:0] held_bytes,
  input logic             start_ok,
  input logic             sending,
  input logic             pkt_nz,
  input logic [THR_W-1:0] thr_bytes
);

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  AST_HOLD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && rd_pop && !rd_last |=> start_ok); // R7

  AST_SF_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sf_en && !sending && !pkt_nz |-> !start_ok); // R2

  AST_CT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sf_en && !sending && !pkt_nz && (held_bytes <= CNT_W'(thr_bytes)) |-> !start_ok); // R3

  AST_THR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_bytes >= THR_W'(64)); // R4

  AST_COMPLETE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_nz |-> start_ok); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (held_bytes == MAXC) && wr_push && !rd_pop |=> (held_bytes == MAXC)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push && !rd_pop |=> held_bytes >= $past(held_bytes)); // R9

endmodule

bind txq_start_ctrl txq_start_ctrl_chk #(.CNT_W(CNT_W), .THR_W(txq_start_pkg::THR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_sf_en  (cfg_sf_en),
  .wr_push    (wr_push),
  .rd_pop     (rd_pop),
  .rd_last    (rd_last),
  .held_bytes (held_bytes),
  .start_ok   (start_ok),
  .sending    (sending),
  .pkt_nz     (pkt_nz),
  .thr_bytes  (thr_bytes)
);

// File: tb/txq_start_ctrl_bench.sv
module txq_start_ctrl_bench;

  localparam int CW = 10;

  logic          clk;
  logic          rst_n;
  logic          cfg_sf_en;
  logic [2:0]    cfg_thr_code;
  logic          wr_push;
  logic          wr_last;
  logic          rd_pop;
  logic          rd_last;
  logic [CW-1:0] held_bytes;
  logic          start_ok;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  txq_start_ctrl #(.CNT_W(CW), .PKT_W(4)) u_txq_start_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sf_en    (cfg_sf_en),
    .cfg_thr_code (cfg_thr_code),
    .wr_push      (wr_push),
    .wr_last      (wr_last),
    .rd_pop       (rd_pop),
    .rd_last      (rd_last),
    .held_bytes   (held_bytes),
    .start_ok     (start_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_thr(input int c);
    if (c < 2) return 64;
    return (((c & 1) != 0) ? 4 : 3) * (32 << ((c - 2) >> 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input bit last);
    for (int i = 0; i < n; i++) begin
      wr_push = 1'b1;
      wr_last = last && (i == n - 1);
      @(negedge clk);
    end
    wr_push = 1'b0;
    wr_last = 1'b0;
    #1;
  endtask

  task automatic pop(input int n, input bit last);
    for (int i = 0; i < n; i++) begin
      rd_pop  = 1'b1;
      rd_last = last && (i == n - 1);
      @(negedge clk);
    end
    rd_pop  = 1'b0;
    rd_last = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_sf_en = 1'b0; cfg_thr_code = 3'd0;
    wr_push = 1'b0; wr_last = 1'b0; rd_pop = 1'b0; rd_last = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R1 start_ok", int'(start_ok), 0);
    chk("R1 held", int'(held_bytes), 0);

    // Threshold sweep: exactly at threshold holds, one more byte starts (R3, R4)
    for (int c = 0; c < 8; c++) begin
      int t;
      t = exp_thr(c);
      cfg_sf_en = 1'b0; cfg_thr_code = 3'(c);
      push(t, 1'b0);
      chk((c == 1) ? "R4 at thr" : "R3 at thr", int'(start_ok), 0);
      push(1, 1'b0);
      chk((c == 1) ? "R4 over thr" : "R3 over thr", int'(start_ok), 1);
      push(1, 1'b1);
      pop(t + 2, 1'b1);
      chk("R8 drained", int'(start_ok), 0);
      chk("R9 drained count", int'(held_bytes), 0);
    end

    // Whole-packet mode over every code (R2, R6)
    for (int c = 0; c < 8; c++) begin
      cfg_sf_en = 1'b1; cfg_thr_code = 3'(c);
      push(600, 1'b0);
      chk("R6 partial ignores code", int'(start_ok), 0);
      push(1, 1'b1);
      chk("R2 complete", int'(start_ok), 1);
      pop(601, 1'b1);
      chk("R2 empty", int'(start_ok), 0);
    end

    // Short complete packet in threshold mode (R5)
    cfg_sf_en = 1'b0; cfg_thr_code = 3'd7;
    push(10, 1'b0);
    chk("R5 short partial", int'(start_ok), 0);
    push(1, 1'b1);
    chk("R5 short complete", int'(start_ok), 1);
    pop(11, 1'b1);

    // Draining packet falls below threshold, config flips (R7)
    cfg_sf_en = 1'b0; cfg_thr_code = 3'd0;
    push(70, 1'b0);
    chk("R7 started", int'(start_ok), 1);
    pop(11, 1'b0);
    chk("R9 count after pops", int'(held_bytes), 59);
    cfg_sf_en = 1'b1; cfg_thr_code = 3'd7;
    #1;
    chk("R7 held below thr", int'(start_ok), 1);
    push(1, 1'b1);
    pop(60, 1'b1);
    chk("R7 released", int'(start_ok), 0);

    // Next packet judged on its own bytes (R8)
    cfg_sf_en = 1'b0; cfg_thr_code = 3'd0;
    push(100, 1'b1);
    push(30, 1'b0);
    chk("R8 two held", int'(held_bytes), 130);
    pop(100, 1'b1);
    chk("R8 next below thr", int'(start_ok), 0);
    chk("R8 next count", int'(held_bytes), 30);
    push(35, 1'b0);
    chk("R8 next over thr", int'(start_ok), 1);

    // Saturation (R9)
    do_reset();
    chk("R1 after reset", int'(held_bytes), 0);
    cfg_sf_en = 1'b1;
    push(1100, 1'b0);
    chk("R9 saturated", int'(held_bytes), 1023);
    chk("R9 sf no start", int'(start_ok), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule